// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers twelve interrupt sources, each with a fixed place in the priority order: a reset-class source, a power-down request that no mask can block, and ten maskable sources. Depending on its sensitivity, each source is either latched on a rising edge or followed as a level. The block gates the requests with a mask register, a global enable and a one-cycle hold-off after each mask write. It then presents the vector address of the highest-priority request that may be taken to an instruction sequencer.

The sequencer takes the presented vector by pulsing an acknowledge. It ends a service routine by pulsing a return. The block keeps a map of the priorities currently in service. With nesting enabled, a request preempts only a strictly higher-priority routine. With nesting disabled, nothing new is issued until every routine has returned. Software reaches the block through register write strobes for the mask and the control bits, through a write-only force/clear port that acts on the edge latches, and through enable and disable strobes.

The outputs come straight from registers, so every output responds one clock edge after the stimulus that causes it.

Top module: `icu_top`

## Requirements
- R1: After reset, no vector is valid. The mask is all zero, so every maskable source is blocked. The control bits are zero. Servicing is enabled, so a forced power-down request (slot 1) is presented as vector 0x002C.
- R2: Slots are numbered by priority, with slot 0 the highest. Their vectors are: slot 0 reset 0x0000, slot 1 power-down 0x002C, slot 2 IRQ2 0x0004, slot 3 level input A 0x0008, slot 4 level input B 0x000C, slot 5 port0 transmit 0x0010, slot 6 port0 receive 0x0014, slot 7 software-settable edge input 0x0018, slot 8 DMA 0x001C, slot 9 port1 transmit/IRQ1 0x0020, slot 10 port1 receive/IRQ0 0x0024, slot 11 timer 0x0028. When several requests are eligible, the lowest-numbered one is presented.
- R3: Mask bit k enables slot k+2, and a 0 bit blocks that slot. The power-down slot ignores the mask.
- R4: In the cycle that follows a mask write, no vector is valid except the reset slot.
- R5: Control bits 2, 1 and 0 select edge sensitivity (1) or level sensitivity (0) for slots 2, 9 and 10. A level-sensitive source is not latched and follows its pin. An edge-sensitive source is latched on a rising edge and stays pending until its vector is acknowledged.
- R6: Slots 1, 5, 6, 7, 8 and 11 are always edge-latched, and slots 3 and 4 are always level-sensitive. A force/clear write sets the edge latches named in its set field and then clears those named in its clear field, with clear winning. It has no effect on a level-sensitive slot.
- R7: The disable strobe blocks every slot except reset, the power-down slot included. The enable strobe restores servicing, and disable wins if both strobes arrive together.
- R8: With control bit 3 set (nesting), a request is presented while routines are in service only if its slot number is strictly lower than the lowest slot in service. A return removes the lowest slot from the service map.
- R9: With control bit 3 clear, once a vector has been acknowledged no further vector other than reset is presented until the service map is empty again.
- R10: The reset slot is level-sensitive and ignores the mask, the enable, the hold-off and the service map. Acknowledging it empties the service map.
- R11: Acknowledging a vector marks its slot as in service and clears its edge latch at the same clock edge. A rising edge that arrives in that same cycle stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_i | input | 12 | Raw request per slot, bit index = slot number |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_data_i | input | 10 | Mask value, bit k enables slot k+2 |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_data_i | input | 4 | Bits 2..0 edge select for slots 2, 9, 10; bit 3 nesting |
| fc_wr_i | input | 1 | Force/clear write strobe |
| fc_set_i | input | 12 | Edge latches to set, bit index = slot |
| fc_clr_i | input | 12 | Edge latches to clear, bit index = slot |
| gie_set_i | input | 1 | Global enable strobe |
| gie_clr_i | input | 1 | Global disable strobe |
| ack_i | input | 1 | Sequencer takes the presented vector |
| ret_i | input | 1 | Sequencer returns from the current routine |
| irq_valid_o | output | 1 | A vector is presented |
| irq_vec_o | output | 14 | Vector address of the presented slot, zero when not valid |

## Verification
Every input is first captured into a register, so a pin level, a latched edge, a force/clear write, a mask or control write, an enable strobe, an acknowledge and a return each show at the outputs just after the next rising edge. The mask-write hold-off covers exactly the cycle after that edge, and the following cycle shows the unmasked result. The bench applies each stimulus on a falling edge and queues the expected valid flag and vector for that same step. The monitor compares them two nanoseconds after the next rising edge, so every result is read one edge after its cause and well away from the edge that changes it.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int NSRC      = 12;
  localparam int IDX_W     = $clog2(NSRC + 1);
  localparam int MASK_W    = NSRC - 2;
  localparam int CTRL_W    = 4;
  localparam int CTRL_NEST = 3;

  // Slot vector address: slot 0 at zero, slot 1 after the last maskable slot,
  // slots 2.. in steps of four words starting at 4.
  function automatic int unsigned slot_addr(input int unsigned idx);
    if (idx == 0) return 0;
    if (idx == 1) return NSRC * 4 - 4;
    return (idx - 1) * 4;
  endfunction

  // Per-slot edge (1) or level (0) selection from the control bits.
  function automatic logic [NSRC-1:0] edge_select(input logic [CTRL_W-1:0] ctrl);
    logic [NSRC-1:0] e;
    e     = '1;
    e[0]  = 1'b0;
    e[3]  = 1'b0;
    e[4]  = 1'b0;
    e[2]  = ctrl[2];
    e[9]  = ctrl[1];
    e[10] = ctrl[0];
    return e;
  endfunction
endpackage

// File: rtl/icu_regs.sv
module icu_regs
  import icu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic [MASK_W-1:0] mask_data,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_data,
  input  logic              gie_set,
  input  logic              gie_clr,
  output logic [MASK_W-1:0] mask_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              gie_q,
  output logic              hold_q
);
  logic [MASK_W-1:0] mask_d;
  logic [CTRL_W-1:0] ctrl_d;
  logic              gie_d;

  always_comb begin
    mask_d = mask_wr ? mask_data : mask_q;
    ctrl_d = ctrl_wr ? ctrl_data : ctrl_q;
    gie_d  = gie_q;
    if (gie_set) gie_d = 1'b1;
    if (gie_clr) gie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ctrl_q <= '0;
      gie_q  <= 1'b1;
      hold_q <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= mask_d;
      if (ctrl_wr) ctrl_q <= ctrl_d;
      if (gie_set || gie_clr) gie_q <= gie_d;
      hold_q <= mask_wr;
    end
  end
endmodule

// File: rtl/icu_latch.sv
module icu_latch
  import icu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] edge_sel,
  input  logic            fc_wr,
  input  logic [NSRC-1:0] fc_set,
  input  logic [NSRC-1:0] fc_clr,
  input  logic [NSRC-1:0] ack_clr,
  output logic [NSRC-1:0] eff
);
  logic [NSRC-1:0] src_q, pend_q, pend_d, rise;

  for (genvar i = 0; i < NSRC; i++) begin : g_slot
    always_comb begin
      rise[i]   = src[i] & ~src_q[i];
      pend_d[i] = (pend_q[i] & ~ack_clr[i]) | rise[i] | (fc_wr & fc_set[i]);
      pend_d[i] = pend_d[i] & ~(fc_wr & fc_clr[i]) & edge_sel[i];
      eff[i]    = edge_sel[i] ? pend_q[i] : src_q[i];
    end

    // R6: a clear named in a force/clear write always leaves the latch empty
    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_wr && fc_clr[i]) |=> !pend_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/icu_select.sv
module icu_select
  import icu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   eff,
  input  logic [MASK_W-1:0] mask_q,
  input  logic              gie_q,
  input  logic              hold_q,
  input  logic              nest,
  input  logic              ack,
  input  logic              ret,
  output logic              valid,
  output logic [IDX_W-1:0]  win,
  output logic [NSRC-1:0]   ack_clr
);
  logic [NSRC-1:0]  cand, inserv_q, inserv_d, ret_oh;
  logic [IDX_W-1:0] cur;
  logic             take, inserv_en;

  always_comb begin
    cur = IDX_W'(NSRC);
    for (int i = NSRC - 1; i >= 0; i--)
      if (inserv_q[i]) cur = IDX_W'(i);
  end

  assign cand[0] = eff[0];
  for (genvar i = 1; i < NSRC; i++) begin : g_cand
    logic allow, unmasked;
    assign allow = nest ? (IDX_W'(i) < cur) : (inserv_q == '0);
    if (i == 1) begin : g_nmi
      assign unmasked = 1'b1;
    end else begin : g_msk
      assign unmasked = mask_q[i-2];
    end
    assign cand[i] = eff[i] & unmasked & gie_q & ~hold_q & allow;
  end

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (cand[i]) win = IDX_W'(i);
  end

  assign valid = |cand;
  assign take  = ack & valid;

  always_comb begin
    ack_clr = '0;
    ret_oh  = '0;
    if (take) ack_clr[win] = 1'b1;
    if (ret && cur != IDX_W'(NSRC)) ret_oh[cur] = 1'b1;
    inserv_en = take | ret;
    if (take && win == '0) inserv_d = '0;
    else inserv_d = (inserv_q & ~ret_oh) | ack_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inserv_q <= '0;
    else if (inserv_en) inserv_q <= inserv_d;
  end

  // R3: a presented maskable slot has its mask bit set
  assert_mask_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && win >= IDX_W'(2)) |-> mask_q[win - IDX_W'(2)]);
  // R8: while nested routines run, only a strictly higher slot is presented
  assert_strict_nest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && nest && inserv_q != '0 && win != '0) |-> (win < cur));
endmodule

// File: rtl/icu_top.sv
module icu_top
  import icu_pkg::*;
#(
  parameter int VEC_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              mask_wr_i,
  input  logic [MASK_W-1:0] mask_data_i,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_data_i,
  input  logic              fc_wr_i,
  input  logic [NSRC-1:0]   fc_set_i,
  input  logic [NSRC-1:0]   fc_clr_i,
  input  logic              gie_set_i,
  input  logic              gie_clr_i,
  input  logic              ack_i,
  input  logic              ret_i,
  output logic              irq_valid_o,
  output logic [VEC_W-1:0]  irq_vec_o
);
  logic [MASK_W-1:0] mask_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              gie_q, hold_q, valid;
  logic [NSRC-1:0]   eff, ack_clr;
  logic [IDX_W-1:0]  win;

  icu_regs u_regs (
    .clk, .rst_n,
    .mask_wr(mask_wr_i), .mask_data(mask_data_i),
    .ctrl_wr(ctrl_wr_i), .ctrl_data(ctrl_data_i),
    .gie_set(gie_set_i), .gie_clr(gie_clr_i),
    .mask_q, .ctrl_q, .gie_q, .hold_q
  );

  icu_latch u_latch (
    .clk, .rst_n,
    .src(src_i), .edge_sel(edge_select(ctrl_q)),
    .fc_wr(fc_wr_i), .fc_set(fc_set_i), .fc_clr(fc_clr_i),
    .ack_clr, .eff
  );

  icu_select u_sel (
    .clk, .rst_n,
    .eff, .mask_q, .gie_q, .hold_q,
    .nest(ctrl_q[CTRL_NEST]), .ack(ack_i), .ret(ret_i),
    .valid, .win, .ack_clr
  );

  assign irq_valid_o = valid;
  assign irq_vec_o   = valid ? VEC_W'(slot_addr(int'(win))) : '0;

  // R4: the cycle after a mask write presents nothing unless reset is requested
  assert_mask_holdoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr_i && !src_i[0]) |=> !irq_valid_o);
  // R7: a disable strobe blocks every slot but reset
  assert_global_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_clr_i && !src_i[0]) |=> !irq_valid_o);
  // R9: sequential mode issues nothing after a non-reset acknowledge
  assert_sequential_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_valid_o && irq_vec_o != '0 && !ctrl_q[CTRL_NEST] && !src_i[0])
    |=> !irq_valid_o);
endmodule

// File: tb/icu_top_test.sv
module icu_top_test;
  logic        clk, rst_n;
  logic [11:0] src_i, fc_set_i, fc_clr_i;
  logic        mask_wr_i, ctrl_wr_i, fc_wr_i, gie_set_i, gie_clr_i, ack_i, ret_i;
  logic [9:0]  mask_data_i;
  logic [3:0]  ctrl_data_i;
  logic        irq_valid_o;
  logic [13:0] irq_vec_o;

  icu_top uut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // staged stimulus, applied by step()
  logic [11:0] s_src = '0, s_set = '0, s_clr = '0;
  logic        s_mwr = 0, s_cwr = 0, s_fwr = 0, s_gs = 0, s_gc = 0, s_ack = 0, s_ret = 0;
  logic [9:0]  s_mask = '0;
  logic [3:0]  s_ctrl = '0;

  bit          q_v[$];
  logic [13:0] q_vec[$];
  string       q_tag[$];

  task automatic step(input bit ev, input logic [13:0] evec, input string tag);
    @(negedge clk);
    src_i = s_src; mask_wr_i = s_mwr; mask_data_i = s_mask;
    ctrl_wr_i = s_cwr; ctrl_data_i = s_ctrl;
    fc_wr_i = s_fwr; fc_set_i = s_set; fc_clr_i = s_clr;
    gie_set_i = s_gs; gie_clr_i = s_gc; ack_i = s_ack; ret_i = s_ret;
    s_mwr = 0; s_cwr = 0; s_fwr = 0; s_set = '0; s_clr = '0;
    s_gs = 0; s_gc = 0; s_ack = 0; s_ret = 0;
    q_v.push_back(ev); q_vec.push_back(ev ? evec : 14'h0); q_tag.push_back(tag);
  endtask

  task automatic force_set(input int slot);
    s_fwr = 1; s_set[slot] = 1'b1;
  endtask
  task automatic force_clr(input int slot);
    s_fwr = 1; s_clr[slot] = 1'b1;
  endtask

  // monitor: compare outputs just after each rising edge
  always @(posedge clk) begin
    #2;
    if (q_v.size() > 0) begin
      bit ev; logic [13:0] evec; string tag;
      ev = q_v.pop_front(); evec = q_vec.pop_front(); tag = q_tag.pop_front();
      n_tests++;
      if (irq_valid_o !== ev || irq_vec_o !== evec) begin
        n_fail++;
        $display("FAIL %s: valid=%0b vec=%h expected valid=%0b vec=%h",
                 tag, irq_valid_o, irq_vec_o, ev, evec);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; src_i = '0; fc_set_i = '0; fc_clr_i = '0; mask_wr_i = 0; ctrl_wr_i = 0;
    fc_wr_i = 0; gie_set_i = 0; gie_clr_i = 0; ack_i = 0; ret_i = 0;
    mask_data_i = '0; ctrl_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    step(0, 0, "R1");                          // reset state
    force_set(11); step(0, 0, "R1");           // mask resets to zero
    force_clr(11); step(0, 0, "R6");
    force_set(1);  step(1, 14'h2C, "R1");      // enabled out of reset, pd unmasked
    s_ack = 1;     step(0, 0, "R9");
    s_ret = 1;     step(0, 0, "R9");

    force_set(11); step(0, 0, "R3");
    s_mwr = 1; s_mask = 10'h3FF; step(0, 0, "R4");
    step(1, 14'h28, "R4");
    force_set(5); force_set(8); step(1, 14'h10, "R2");
    s_ack = 1; step(0, 0, "R9");
    step(0, 0, "R9");
    s_ret = 1; step(1, 14'h1C, "R2");
    s_ack = 1; step(0, 0, "R11");
    s_ret = 1; step(1, 14'h28, "R2");
    s_ack = 1; step(0, 0, "R11");
    s_ret = 1; step(0, 0, "R11");              // latches cleared by acknowledge

    s_mwr = 1; s_mask = 10'h1FF; force_set(11); step(0, 0, "R4");
    step(0, 0, "R3");                          // mask bit 9 blocks slot 11
    s_mwr = 1; s_mask = 10'h3FF; step(0, 0, "R4");
    step(1, 14'h28, "R3");
    force_clr(11); step(0, 0, "R6");

    s_src[3] = 1; step(1, 14'h08, "R5");
    s_src[3] = 0; step(0, 0, "R5");
    force_set(4); step(0, 0, "R6");            // force ignored on level slot
    s_src[2] = 1; step(1, 14'h04, "R5");
    s_src[2] = 0; step(0, 0, "R5");
    s_cwr = 1; s_ctrl = 4'b0100; step(0, 0, "R5");
    s_src[2] = 1; step(1, 14'h04, "R5");
    s_src[2] = 0; step(1, 14'h04, "R5");       // edge latched
    s_ack = 1; step(0, 0, "R11");
    s_ret = 1; step(0, 0, "R5");

    force_set(7); step(1, 14'h18, "R6");
    force_clr(7); step(0, 0, "R6");

    force_set(1); s_gc = 1; step(0, 0, "R7");
    step(0, 0, "R7");
    s_gs = 1; step(1, 14'h2C, "R7");
    s_ack = 1; step(0, 0, "R7");
    s_ret = 1; step(0, 0, "R7");

    s_cwr = 1; s_ctrl = 4'b1100; step(0, 0, "R8");
    force_set(11); step(1, 14'h28, "R8");
    s_ack = 1; step(0, 0, "R8");
    force_set(8); step(1, 14'h1C, "R8");       // strictly higher preempts
    s_ack = 1; step(0, 0, "R8");
    force_set(8); step(0, 0, "R8");            // equal priority waits
    s_ret = 1; step(1, 14'h1C, "R8");
    s_ack = 1; step(0, 0, "R8");
    s_ret = 1; step(0, 0, "R8");
    s_ret = 1; step(0, 0, "R8");

    force_set(5); step(1, 14'h10, "R8");
    s_ack = 1; step(0, 0, "R8");
    force_set(8); step(0, 0, "R8");
    s_src[0] = 1; s_gc = 1; step(1, 14'h0, "R10");
    s_ack = 1; step(1, 14'h0, "R10");
    s_src[0] = 0; s_gs = 1; step(1, 14'h1C, "R10"); // service map emptied
    s_ack = 1; step(0, 0, "R11");
    s_ret = 1; step(0, 0, "R11");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule